// File: doc/BRIEF.md
# Double-Buffered Converter Input Register Pair

This block is the parallel write path in front of a 14-bit digital-to-analog converter. It has two storage stages. The first is a holding register that a host loads from a 14-bit parallel bus by driving chip-select and write low. The second is a code register that feeds the converter and copies the holding register while a separate load strobe is low. Because the stages are separate, software can stage a new word without disturbing the analog output. It can then update the output at a chosen moment, or hold every strobe low so that the bus passes through both stages.

All three strobes are active low and asynchronous to the system clock. Each one passes through a two-flop synchroniser. The data bus passes through a matching two-flop pipeline, so data and strobes stay aligned. Transparency is evaluated once per clock: an enabled stage takes its input on every edge. A change at the pins therefore reaches `dac_code` on the third rising edge after it is set up.

A one-cycle `dac_updated` pulse accompanies every edge at which the code register takes a new value. The data path is a strobed register interface and carries no back-pressure, so it has no valid/ready handshake.

Top module: `dac_dual_stage_latch`

## Requirements
- R1: While `rst_n` is low and right after its release, `dac_code` is 0 and `dac_updated` is 0. Both registers clear to 0, and the load strobe counts as inactive until a low level has passed the synchroniser.
- R2: When `cs_n` and `wr_n` are both low, the holding register takes `bus_data` on every clock.
- R3: When `cs_n` is high or `wr_n` is high, the holding register keeps its value whatever the level of `ld_n`. The holding register is observed through a later load.
- R4: While `ld_n` is low, the code register takes the holding register's value on every clock, so `dac_code` tracks it.
- R5: While `ld_n` is high, `dac_code` does not change, even when the holding register is loaded.
- R6: With `cs_n`, `wr_n` and `ld_n` all low, a new `bus_data` word appears on `dac_code` three rising edges after it is applied, and each later bus change follows with the same latency.
- R7: `dac_updated` is 1 for exactly the clock cycle that follows an edge at which `dac_code` changed. It is 0 when a load rewrites the same value.
- R8: Strobes are synchronised through two flip-flops. A falling `ld_n` leaves `dac_code` unchanged after two rising edges and updates it on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip-select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| ld_n | input | 1 | Load strobe into the code register, active low, asynchronous |
| bus_data | input | 14 | Parallel data word |
| dac_code | output | 14 | Code presented to the converter |
| dac_updated | output | 1 | One-cycle pulse after `dac_code` changes |

## Verification
The load path is tried in four ways: a bus write with the load strobe high, a load pulse after the write, writes blocked by either chip-select or write high while load is low, and all three strobes held low together. The first tells the holding stage apart from the code stage, and the second shows the transfer. The blocked writes separate the two gating strobes from each other and from the load. Fully transparent mode is driven with a changing bus to show pass-through at a fixed three-edge latency. The update pulse is checked both on a real change and on a reload of the same value, which tells a change detector apart from a load echo.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;
  localparam int unsigned STROBE_N = 3;

  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic ld_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, ld_n: 1'b1};
endpackage

// File: rtl/dac_sync_chain.sv
module dac_sync_chain #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stage_q[s] <= din;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

  // R8: each stage passes on the value the stage before held one edge earlier
  p_chain_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stage_q[0] == $past(din));
endmodule

// File: rtl/dac_hold_stage.sv
module dac_hold_stage #(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_act,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] q_next
);
  always_comb begin
    q_next = q;
    if (wr_act) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  p_hold_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |=> q == $past(d));
  p_hold_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_act |=> $stable(q));
endmodule

// File: rtl/dac_code_stage.sv
module dac_code_stage #(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_act,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q,
  output logic              changed
);
  logic [DATA_W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (ld_act) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      changed <= 1'b0;
    end else begin
      q       <= q_next;
      changed <= (q_next != q);
    end
  end

  p_code_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_act |=> q == $past(d));
  p_code_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_act |=> $stable(q));
endmodule

// File: rtl/dac_dual_stage_latch.sv
module dac_dual_stage_latch
  import dac_latch_pkg::*;
#(
  parameter int unsigned DATA_W      = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic [DATA_W-1:0] bus_data,
  output logic [DATA_W-1:0] dac_code,
  output logic              dac_updated
);
  strobe_t           strobe_raw, strobe_s;
  logic [DATA_W-1:0] data_s;
  logic [DATA_W-1:0] hold_q, hold_next;
  logic              wr_act, ld_act;

  assign strobe_raw = '{cs_n: cs_n, wr_n: wr_n, ld_n: ld_n};

  dac_sync_chain #(.W(STROBE_N), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)) u_strobe_sync (
    .clk(clk), .rst_n(rst_n), .din(strobe_raw), .dout(strobe_s));

  dac_sync_chain #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .din(bus_data), .dout(data_s));

  assign wr_act = !strobe_s.cs_n && !strobe_s.wr_n;
  assign ld_act = !strobe_s.ld_n;

  dac_hold_stage #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .d(data_s),
    .q(hold_q), .q_next(hold_next));

  // the code stage sees the holding stage's next value, so both stages
  // open together pass the bus straight through in one evaluation
  dac_code_stage #(.DATA_W(DATA_W)) u_code (
    .clk(clk), .rst_n(rst_n), .ld_act(ld_act), .d(hold_next),
    .q(dac_code), .changed(dac_updated));

  p_pulse_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dac_updated |-> dac_code != $past(dac_code));
  p_no_pulse_when_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_updated |-> $stable(dac_code));
  p_transparent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && ld_act) |=> dac_code == $past(data_s));
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (dac_code == '0 && !dac_updated && hold_q == '0));
endmodule

// File: tb/dac_dual_stage_latch_bench.sv
module dac_dual_stage_latch_bench;
  localparam int W = 14;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, wr_n = 1, ld_n = 1;
  logic [W-1:0] bus_data = '0;
  logic [W-1:0] dac_code;
  logic dac_updated;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dac_dual_stage_latch u_dac_dual_stage_latch (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
    .bus_data(bus_data), .dac_code(dac_code), .dac_updated(dac_updated));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired: actual=%0d cycles expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic w, input logic l, input logic [W-1:0] d);
    @(negedge clk);
    cs_n = c; wr_n = w; ld_n = l; bus_data = d;
  endtask

  // moves to the negedge after n more rising edges
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0;
    cs_n = 0; wr_n = 0; ld_n = 0; bus_data = 14'h1234;
    edges(3);
    chk("R1 code in reset", dac_code, 0);
    chk("R1 pulse in reset", dac_updated, 0);
    drive(1, 1, 1, '0);
    rst_n = 1;
    edges(4);
    chk("R1 code after reset", dac_code, 0);
    chk("R1 pulse after reset", dac_updated, 0);
  endtask

  task automatic t_stage_then_load;
    drive(0, 0, 1, 14'h2A5C);
    edges(4);
    chk("R5 code held while load high", dac_code, 0);
    drive(1, 1, 1, 14'h0001);
    edges(3);
    drive(1, 1, 0, 14'h0001);
    edges(2);  // falling edge + 2 rising edges: not yet through the synchroniser
    chk("R8 no update after two edges", dac_code, 0);
    edges(1);
    chk("R4 code takes holding value", dac_code, 14'h2A5C);
    chk("R7 pulse on change", dac_updated, 1);
    edges(1);
    chk("R7 pulse lasts one cycle", dac_updated, 0);
    chk("R4 code stays while tracking", dac_code, 14'h2A5C);
    drive(1, 1, 1, 14'h0001);
    edges(3);
  endtask

  task automatic t_blocked_writes;
    drive(1, 0, 0, 14'h3FFF);  // chip-select high
    edges(4);
    chk("R3 cs high blocks write", dac_code, 14'h2A5C);
    chk("R7 no pulse on same value", dac_updated, 0);
    drive(0, 1, 0, 14'h1111);  // write high
    edges(4);
    chk("R3 wr high blocks write", dac_code, 14'h2A5C);
    drive(1, 1, 1, 14'h0);
    edges(3);
  endtask

  task automatic t_same_value_reload;
    drive(0, 0, 1, 14'h2A5C);
    edges(1);
    drive(1, 1, 1, 14'h0);
    edges(3);
    drive(1, 1, 0, 14'h0);
    edges(3);
    chk("R7 reload of same value no pulse", dac_updated, 0);
    chk("R2 rewrite of same word", dac_code, 14'h2A5C);
    drive(1, 1, 1, 14'h0);
    edges(3);
  endtask

  task automatic t_transparent;
    drive(0, 0, 0, 14'h0F0F);
    edges(2);
    chk("R6 not through after two edges", dac_code, 14'h2A5C);
    edges(1);
    chk("R6 pass-through first word", dac_code, 14'h0F0F);
    chk("R7 pulse on pass-through", dac_updated, 1);
    drive(0, 0, 0, 14'h3001);
    edges(3);
    chk("R6 pass-through second word", dac_code, 14'h3001);
    drive(0, 0, 1, 14'h0777);  // load released at the same moment
    edges(4);
    chk("R5 code frozen after load release", dac_code, 14'h3001);
    drive(1, 1, 0, 14'h0);
    edges(3);
    chk("R2 holding took word with load high", dac_code, 14'h0777);
    drive(1, 1, 1, 14'h0);
    edges(3);
  endtask

  initial begin
    t_reset();
    t_stage_then_load();
    t_blocked_writes();
    t_same_value_reload();
    t_transparent();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule